// File: doc/BRIEF.md
# Flash Ready Status Poller

This block decides when a parallel NOR flash has finished an internal program or erase operation. The flash has no busy pin, so it reports progress through the byte it returns on ordinary read cycles. After a start pulse the poller issues repeated byte reads through a simple request/acknowledge handshake to an external bus master. It inspects each returned byte until the flash shows that it is ready, or until an iteration limit is reached.

There are two detection modes. In toggle mode, bit 6 of the status flips on every read while the flash is busy. Completion is seen when two reads in a row return the same bit 6. In data-polling mode, bit 7 reads as the complement of bit 7 of the byte being programmed until the operation ends. The poller can leave a fixed number of idle clock cycles before each comparison read; slow erase operations want a long gap, on the order of milliseconds. On finishing it pulses `done_o`. It also raises a sticky warning when the wait was unusually long and a sticky timeout flag when it gave up.

The iteration counter is `ITER_W` bits wide (28 by default). By default it gives up after 0x0FFFFFFF comparison reads and warns beyond 0x100000.

Top module: `flash_ready_poller`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `rd_req_o`, `done_o`, `timeout_o` and `slow_o` are all 0.
- R2: A `start_i` pulse while idle latches `mode_i` (0 = toggle, 1 = data polling) and bit 7 of `expect_i`, and `busy_o` is 1 from the next cycle. A `start_i` while busy is ignored, and changes of `mode_i`/`expect_i` during an operation have no effect on its outcome.
- R3: In toggle mode only bit 6 of `rd_data_i` is used. The first read of an operation only records a reference value. Each later read is compared with the read before it, and the reference is replaced by the new value. The operation completes on the first read whose bit 6 equals the previous one.
- R4: In data-polling mode only bit 7 of `rd_data_i` is used. Every read is compared with the latched expected bit 7, and the operation completes on the first match.
- R5: Before every comparison read, `rd_req_o` stays low for exactly `GAP_CYCLES` cycles while busy. The toggle-mode reference read is requested in the first cycle after start with no gap. In data mode the first read follows a gap.
- R6: `rd_req_o` stays high until a cycle in which `rd_ack_i` is sampled high. `rd_data_i` is used only in that cycle.
- R7: `done_o` is a one-cycle pulse in the cycle after the final acknowledge, and `busy_o` falls in that same cycle.
- R8: Each comparison read counts one iteration. If the `ITER_LIMIT`-th comparison does not match, the operation ends with `done_o` and `timeout_o` set. A match on exactly that read ends without timeout. `timeout_o` holds until the next accepted start clears it.
- R9: `slow_o` is set when an operation ends after more than `WARN_AT` comparison reads, whether it ends by match or by timeout. `slow_o` holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | Detection mode: 0 toggle bit, 1 data polling |
| expect_i | input | DATA_W | Byte being programmed; bit 7 used in data-polling mode |
| rd_req_o | output | 1 | Read request to the bus master |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` valid in this cycle |
| rd_data_i | input | DATA_W | Byte returned by the flash |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky: iteration limit reached without completion |
| slow_o | output | 1 | Sticky: completion took more than `WARN_AT` comparisons |

## Verification
The hardest situation to reach is the limit boundary. A match on the very last allowed comparison must finish cleanly, while a mismatch there must time out, and the two modes reach that read at different read indices because toggle mode spends one read on its reference. The bench shrinks `ITER_LIMIT` and `WARN_AT` by parameter and drives a behavioural flash whose busy length is chosen per operation. It places completion one read before, on and after each threshold. A per-cycle behavioural model then confirms the flag values and the gap lengths.

// File: rtl/flash_poll_pkg.sv
// Shared types for the flash ready status poller.
// Assumes: a single clock domain; encodings are local to this block.
package flash_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_READ = 2'd2
    } poll_state_t;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_DATA   = 1'b1
    } poll_mode_t;

endpackage

// File: rtl/poll_gap_timer.sv
// Counts the idle cycles left before the next comparison read.
// Assumes: run is high only while the controller sits in its gap state;
// expired_o is high on the last gap cycle so the controller leaves after
// exactly GAP cycles. With GAP = 0 the controller never enters the gap state.
module poll_gap_timer #(
    parameter int unsigned GAP = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired_o
);
    localparam int unsigned LAST = (GAP == 0) ? 0 : GAP - 1;
    localparam int unsigned CW   = (GAP < 2) ? 1 : $clog2(GAP);

    logic [CW-1:0] cnt_q;

    assign expired_o = run && (cnt_q == CW'(LAST));

    // Count up while in the gap, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r5_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST));

endmodule

// File: rtl/poll_iter_counter.sv
// Saturating count of comparison reads in the current operation.
// Assumes: clear arrives with the accepted start; step marks one
// comparison read. Outputs describe the count including the current step.
module poll_iter_counter #(
    parameter int unsigned CNT_W   = 28,
    parameter int unsigned LIMIT   = 32'h0FFF_FFFF,
    parameter int unsigned WARN_AT = 32'h0010_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last_o,
    output logic over_warn_o
);
    localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_AT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Value after the pending step, held at the limit.
    always_comb begin
        cnt_inc = (cnt_q == LIM_V) ? cnt_q : cnt_q + 1'b1;
    end

    assign last_o      = (cnt_inc == LIM_V);
    assign over_warn_o = (cnt_inc > WARN_V);

    // Register the count; start clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_inc;
        end
    end

    a_r8_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/poll_status_compare.sv
// Decides whether a returned status byte shows the flash ready.
// Assumes: sample is high for every acknowledged read of an operation
// and clear with the accepted start. Toggle mode keeps a one-bit
// reference of the previous read; data mode compares with the expected bit.
module poll_status_compare #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned TOGGLE_BIT = 6,
    parameter int unsigned POLL_BIT   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     sample,
    input  flash_poll_pkg::poll_mode_t mode,
    input  logic                     exp_bit,
    input  logic [DATA_W-1:0]        data,
    output logic                     ref_only_o,
    output logic                     match_o
);
    import flash_poll_pkg::*;

    logic ref_valid_q;
    logic ref_bit_q;
    logic unused_data_bits;

    assign unused_data_bits = ^data;
    assign ref_only_o = (mode == MODE_TOGGLE) && !ref_valid_q;

    // Ready test for the byte currently on the data input.
    always_comb begin
        if (mode == MODE_DATA) begin
            match_o = (data[POLL_BIT] == exp_bit);
        end else begin
            match_o = (data[TOGGLE_BIT] == ref_bit_q);
        end
    end

    // Keep the toggle bit of the latest read as the next reference.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_valid_q <= 1'b0;
            ref_bit_q   <= 1'b0;
        end else if (sample && mode == MODE_TOGGLE) begin
            ref_valid_q <= 1'b1;
            ref_bit_q   <= data[TOGGLE_BIT];
        end
    end

    a_r3_reference_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && mode == MODE_TOGGLE && !clear) |=> ref_valid_q);

endmodule

// File: rtl/flash_ready_poller.sv
// Flash ready status poller: issues status reads after a start pulse and
// ends the operation when the toggle bit stops flipping or the polled bit
// matches the expected data, or when the iteration limit is reached.
// Assumes: the bus master answers each request with one rd_ack_i pulse
// carrying the byte; start_i is ignored while an operation runs.
module flash_ready_poller #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned TOGGLE_BIT = 6,
    parameter int unsigned POLL_BIT   = 7,
    parameter int unsigned GAP_CYCLES = 0,
    parameter int unsigned ITER_W     = 28,
    parameter int unsigned ITER_LIMIT = 32'h0FFF_FFFF,
    parameter int unsigned WARN_AT    = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] expect_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              slow_o
);
    import flash_poll_pkg::*;

    localparam poll_state_t AFTER_READ = (GAP_CYCLES == 0) ? ST_READ : ST_GAP;

    poll_state_t state_q, state_d;
    poll_mode_t  mode_q;
    logic        exp_bit_q;
    logic        done_q, timeout_q, slow_q;
    logic        take_start, ack_ev, cmp_ev, finish;
    logic        ref_only, match, last_cmp, over_warn, gap_done;
    logic        unused_expect_bits;

    assign unused_expect_bits = ^expect_i;

    assign take_start = start_i && (state_q == ST_IDLE);
    assign ack_ev     = (state_q == ST_READ) && rd_ack_i;
    assign cmp_ev     = ack_ev && !ref_only;
    assign finish     = cmp_ev && (match || last_cmp);

    poll_gap_timer #(
        .GAP (GAP_CYCLES)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_GAP),
        .expired_o (gap_done)
    );

    poll_iter_counter #(
        .CNT_W   (ITER_W),
        .LIMIT   (ITER_LIMIT),
        .WARN_AT (WARN_AT)
    ) u_iter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (take_start),
        .step        (cmp_ev),
        .last_o      (last_cmp),
        .over_warn_o (over_warn)
    );

    poll_status_compare #(
        .DATA_W     (DATA_W),
        .TOGGLE_BIT (TOGGLE_BIT),
        .POLL_BIT   (POLL_BIT)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (take_start),
        .sample     (ack_ev),
        .mode       (mode_q),
        .exp_bit    (exp_bit_q),
        .data       (rd_data_i),
        .ref_only_o (ref_only),
        .match_o    (match)
    );

    // Next-state choice for the read sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (take_start) begin
                    if (poll_mode_t'(mode_i) == MODE_TOGGLE || GAP_CYCLES == 0) begin
                        state_d = ST_READ;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (gap_done) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (ack_ev) begin
                    state_d = finish ? ST_IDLE : AFTER_READ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch the operation's mode and expected bit on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_TOGGLE;
            exp_bit_q <= 1'b0;
        end else if (take_start) begin
            mode_q    <= poll_mode_t'(mode_i);
            exp_bit_q <= expect_i[POLL_BIT];
        end
    end

    // Completion pulse and sticky result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            slow_q    <= 1'b0;
        end else begin
            done_q <= finish;
            if (take_start) begin
                timeout_q <= 1'b0;
                slow_q    <= 1'b0;
            end else if (finish) begin
                timeout_q <= !match;
                slow_q    <= over_warn;
            end
        end
    end

    assign rd_req_o  = (state_q == ST_READ);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign timeout_o = timeout_q;
    assign slow_o    = slow_q;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> done_o);

    a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    a_r2_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(mode_q));

endmodule

// File: tb/flash_ready_poller_bench.sv
`timescale 1ns/1ps
// Bench: behavioural flash responder plus a per-cycle behavioural model of
// the poller's flags, and per-operation checks of read counts and results.
module flash_ready_poller_bench;
    localparam int GAP  = 2;
    localparam int LIM  = 20;
    localparam int WARN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] expect_i = 8'h00;
    logic       rd_ack_i = 1'b0;
    logic [7:0] rd_data_i = 8'h00;
    logic       rd_req_o, busy_o, done_o, timeout_o, slow_o;

    int checks = 0;
    int bad = 0;
    int cyc = 0;

    // behavioural flash state
    logic       fm_mode = 1'b0;
    logic [7:0] fm_exp = 8'h00;
    int         fm_busy_n = 0;
    int         fm_idx = 0;

    // per-cycle model state
    logic m_busy = 0, m_done = 0, m_to = 0, m_slow = 0;
    logic m_mode = 0, m_exp7 = 0, m_haveref = 0, m_ref = 0;
    logic first_rd = 0, prev_req = 0;
    int   m_k = 0;
    int   gap_run = 0;

    always #2.5 clk = ~clk;

    flash_ready_poller #(
        .GAP_CYCLES (GAP),
        .ITER_LIMIT (LIM),
        .WARN_AT    (WARN)
    ) u_flash_ready_poller (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .expect_i  (expect_i),
        .rd_req_o  (rd_req_o),
        .rd_ack_i  (rd_ack_i),
        .rd_data_i (rd_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .timeout_o (timeout_o),
        .slow_o    (slow_o)
    );

    function automatic logic [7:0] flash_byte(input int n);
        logic [7:0] b;
        b = 8'(n * 37 + 11);
        if (fm_mode == 1'b0) begin
            b[6] = (n <= fm_busy_n) ? n[0] : fm_busy_n[0];
        end else begin
            b[7] = (n < fm_busy_n) ? ~fm_exp[7] : fm_exp[7];
        end
        return b;
    endfunction

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Flash responder: one acknowledge per request, answered at the falling edge.
    always @(negedge clk) begin
        if (rd_req_o && !rd_ack_i) begin
            rd_data_i = flash_byte(fm_idx);
            fm_idx    = fm_idx + 1;
            rd_ack_i  = 1'b1;
        end else begin
            rd_ack_i  = 1'b0;
        end
    end

    // Per-cycle model, evaluated 1 ns after each rising edge.
    always @(posedge clk) begin
        logic match;
        int   exp_gap;
        #1;
        cyc++;
        if (cyc > 150000) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            finish_up();
        end
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_to = 0; m_slow = 0;
            prev_req = 0; gap_run = 0;
        end else begin
            m_done = 0;
            if (!m_busy && start_i) begin
                m_busy = 1; m_mode = mode_i; m_exp7 = expect_i[7];
                m_haveref = 0; m_k = 0; m_to = 0; m_slow = 0;
                first_rd = 1; gap_run = 0;
            end else if (m_busy && rd_ack_i) begin
                if (m_mode == 1'b0 && !m_haveref) begin
                    m_haveref = 1;
                    m_ref = rd_data_i[6];
                end else begin
                    m_k++;
                    if (m_mode == 1'b0) begin
                        match = (rd_data_i[6] == m_ref);
                        m_ref = rd_data_i[6];
                    end else begin
                        match = (rd_data_i[7] == m_exp7);
                    end
                    if (match || m_k == LIM) begin
                        m_busy = 0; m_done = 1;
                        m_to = !match;
                        m_slow = (m_k > WARN);
                    end
                end
            end
            // R2 R7 R8 R9: flags against the model every cycle
            checks++;
            if (busy_o !== m_busy || done_o !== m_done ||
                timeout_o !== m_to || slow_o !== m_slow) begin
                bad++;
                $display("FAIL R7/R8/R9 cycle %0d: actual busy=%b done=%b to=%b slow=%b expected %b %b %b %b",
                         cyc, busy_o, done_o, timeout_o, slow_o, m_busy, m_done, m_to, m_slow);
            end
            // R6: a request may only drop on an acknowledged cycle
            if (prev_req && !rd_req_o && !rd_ack_i) begin
                chk("R6 request dropped without ack", 0, 1);
            end
            // R5: idle cycles before each request
            if (rd_req_o && !prev_req) begin
                exp_gap = (m_mode == 1'b0 && first_rd) ? 0 : GAP;
                chk("R5 gap before read", gap_run, exp_gap);
                first_rd = 0;
                gap_run = 0;
            end else if (m_busy && !rd_req_o) begin
                gap_run++;
            end
            prev_req = rd_req_o;
        end
    end

    // Runs one operation; checks reads, timeout and warning from R3/R4/R8/R9.
    task automatic run_op(input string tag, input logic md, input logic [7:0] ex,
                          input int bn, input logic poke);
        int k, exp_reads, waited;
        logic exp_to, exp_sl;
        k = bn + 1;
        exp_to = (k > LIM);
        if (k > LIM) k = LIM;
        exp_reads = (md == 1'b0) ? k + 1 : k;
        exp_sl = (k > WARN);
        @(negedge clk);
        fm_mode = md; fm_exp = ex; fm_busy_n = bn; fm_idx = 0;
        mode_i = md; expect_i = ex; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mode_i = ~md; expect_i = ~ex;   // R2: later input changes ignored
        chk({tag, " R2 busy after start"}, int'(busy_o), 1);
        chk({tag, " R8 timeout cleared by start"}, int'(timeout_o), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;            // R2: start while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R7 done seen"}, int'(done_o), 1);
        chk({tag, " R3/R4 read count"}, fm_idx, exp_reads);
        chk({tag, " R8 timeout"}, int'(timeout_o), int'(exp_to));
        chk({tag, " R9 slow"}, int'(slow_o), int'(exp_sl));
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, int'(done_o), 0);
        chk({tag, " R7 idle after done"}, int'(busy_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 req", int'(rd_req_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 timeout", int'(timeout_o), 0);
        chk("R1 slow", int'(slow_o), 0);

        run_op("toggle3",  1'b0, 8'h00, 3, 1'b0);   // R3
        run_op("data2",    1'b1, 8'h80, 2, 1'b0);   // R4
        run_op("data0",    1'b1, 8'h00, 0, 1'b0);   // R4 immediate match
        run_op("toggle0",  1'b0, 8'h5A, 0, 1'b0);   // R3 shortest
        run_op("toggle5",  1'b0, 8'h00, 5, 1'b0);   // R9 at warn limit
        run_op("toggle6",  1'b0, 8'h00, 6, 1'b0);   // R9 one past
        run_op("data5",    1'b1, 8'h80, 5, 1'b0);   // R9 data edge
        run_op("data6",    1'b1, 8'h7F, 6, 1'b0);   // R9 data past
        run_op("toggleTO", 1'b0, 8'h00, 50, 1'b0);  // R8 timeout
        run_op("data1",    1'b1, 8'h80, 1, 1'b0);   // R8 flags cleared
        run_op("dataTO",   1'b1, 8'hFF, 50, 1'b0);  // R8 timeout data
        run_op("toggle19", 1'b0, 8'h00, 19, 1'b0);  // R8 match on last
        run_op("data19",   1'b1, 8'h80, 19, 1'b0);  // R8 match on last
        run_op("poke",     1'b0, 8'h00, 3, 1'b1);   // R2 start while busy
        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule